// File: doc/BRIEF.md
# Frame Sync Pulse Generator

This block derives an 8 kHz frame sync from a fast synchronous clock by dividing that clock by a fixed, even ratio (the clock frequency over 8 kHz, for example 2430 for 19.44 MHz). The output can run in either of two shapes. One is a square wave with exactly half the frame high. The other is a high-going pulse whose width is a count of clock cycles taken from a 4-bit control field.

Every frame begins with a one-cycle start strobe. The rising edge of the frame output coincides with that strobe. The shape controls are sampled only at frame boundaries, so changing them mid-frame never truncates or stretches the frame in progress. While reset is held, the output, the strobe and the internal counter all stay low. The first frame begins in the first cycle after reset is released.

Top module: `frame_sync_gen`

## Requirements
- R1: frame_start_o is high once every DIV_RATIO clock cycles.
- R2: frame_start_o is high for exactly one cycle per frame.
- R3: With the latched mode bit at 0, frame_o is high for the first DIV_RATIO/2 cycles of each frame, starting in the strobe cycle, and low for the rest.
- R4: With the latched mode bit at 1, frame_o is high for the first W cycles of each frame, starting in the strobe cycle, where W is the 4-bit width field (1 to 15), and low for the rest.
- R5: A width field of 0 in pulse mode gives a pulse one cycle wide.
- R6: pulse_mode_i and pulse_width_i are sampled only on the clock edge that starts a frame. A change made after that edge leaves the current frame unchanged and applies from the next frame.
- R7: While rst_ni is low, frame_o and frame_start_o are low. In the first cycle after release, frame_start_o and frame_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Synchronous high-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_mode_i | input | 1 | 0: half-frame square wave, 1: programmable pulse |
| pulse_width_i | input | 4 | Pulse width in clock cycles (0 is treated as 1) |
| frame_o | output | 1 | Frame sync output |
| frame_start_o | output | 1 | One-cycle strobe in the first cycle of each frame |

## Verification
The hardest case to reach is a control change landing inside a frame that is already running. The shape must then be held until the next boundary, which cannot be seen by watching steady-state frames. The bench waits for a strobe and rewrites the mode or width a cycle or two later. It then counts the high cycles of that same frame against the old setting and those of the following frame against the new one. The bench is built with a short division ratio so that full frames, the zero-width mapping and the widest pulse all fit in a few hundred cycles.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int unsigned PW_W = 4;

  typedef struct packed {
    logic            pulse_mode;
    logic [PW_W-1:0] width;
  } fsync_cfg_t;
endpackage

// File: rtl/fsync_divider.sv
module fsync_divider #(
  parameter int unsigned DIV_RATIO = 2430,
  localparam int unsigned CNT_W = $clog2(DIV_RATIO)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             boundary_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // first edge after reset opens a frame
  assign boundary_o = !run_q || (cnt_q == CNT_W'(DIV_RATIO - 1));
  assign cnt_next_o = boundary_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next_o;
      run_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fsync_cfg_latch.sv
module fsync_cfg_latch
  import fsync_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            boundary_i,
  input  logic            pulse_mode_i,
  input  logic [PW_W-1:0] pulse_width_i,
  output fsync_cfg_t      cfg_next_o
);
  fsync_cfg_t cfg_q;
  fsync_cfg_t cfg_in;

  always_comb begin
    cfg_in.pulse_mode = pulse_mode_i;
    cfg_in.width      = (pulse_width_i == '0) ? PW_W'(1) : pulse_width_i;
  end

  assign cfg_next_o = boundary_i ? cfg_in : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{pulse_mode: 1'b0, width: PW_W'(1)};
    end else begin
      cfg_q <= cfg_next_o;
    end
  end
endmodule

// File: rtl/fsync_shaper.sv
module fsync_shaper
  import fsync_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 2430,
  localparam int unsigned CNT_W = $clog2(DIV_RATIO),
  localparam int unsigned HALF  = DIV_RATIO / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boundary_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  input  fsync_cfg_t       cfg_next_i,
  output logic             frame_o,
  output logic             frame_start_o
);
  logic [31:0] pos;
  logic        level_d;

  assign pos = 32'(cnt_next_i);

  always_comb begin
    if (cfg_next_i.pulse_mode) level_d = pos < 32'(cfg_next_i.width);
    else                       level_d = pos < 32'(HALF);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o       <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      frame_o       <= level_d;
      frame_start_o <= boundary_i;
    end
  end
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
  import fsync_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 2430,
  localparam int unsigned CNT_W = $clog2(DIV_RATIO)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pulse_mode_i,
  input  logic [PW_W-1:0] pulse_width_i,
  output logic            frame_o,
  output logic            frame_start_o
);
  logic             boundary;
  logic [CNT_W-1:0] cnt_next;
  fsync_cfg_t       cfg_next;

  fsync_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_o (boundary),
    .cnt_next_o (cnt_next)
  );

  fsync_cfg_latch u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .boundary_i    (boundary),
    .pulse_mode_i  (pulse_mode_i),
    .pulse_width_i (pulse_width_i),
    .cfg_next_o    (cfg_next)
  );

  fsync_shaper #(.DIV_RATIO(DIV_RATIO)) u_shape (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .boundary_i    (boundary),
    .cnt_next_i    (cnt_next),
    .cfg_next_i    (cfg_next),
    .frame_o       (frame_o),
    .frame_start_o (frame_start_o)
  );
endmodule

// File: rtl/fsync_chk.sv
module fsync_chk #(
  parameter int unsigned DIV_RATIO = 2430,
  localparam int unsigned GAP_W = $clog2(DIV_RATIO) + 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic frame_o,
  input logic frame_start_o
);
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (frame_start_o) begin
      gap_q  <= GAP_W'(1);
      seen_q <= 1'b1;
    end else if (gap_q <= GAP_W'(DIV_RATIO)) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_FRAME_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && seen_q) |-> (gap_q == GAP_W'(DIV_RATIO))); // R1

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o); // R2

  AST_RISE_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_o) |-> frame_start_o); // R3

  AST_HIGH_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> frame_o); // R5

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!frame_o && !frame_start_o); // R7
    end
  end
endmodule

bind frame_sync_gen fsync_chk #(.DIV_RATIO(DIV_RATIO)) u_fsync_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_o       (frame_o),
  .frame_start_o (frame_start_o)
);

// File: tb/tb_frame_sync_gen.sv
module tb_frame_sync_gen;
  localparam int DIV  = 20;
  localparam int HALF = DIV / 2;
  localparam int NV   = 8;
  // {mode, width[3:0], expected high cycles[4:0]}
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 4'd3,  5'd10},
    {1'b1, 4'd1,  5'd1},
    {1'b1, 4'd0,  5'd1},
    {1'b1, 4'd15, 5'd15},
    {1'b1, 4'd7,  5'd7},
    {1'b0, 4'd15, 5'd10},
    {1'b1, 4'd2,  5'd2},
    {1'b0, 4'd0,  5'd10}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pulse_mode_i = 1'b0;
  logic [3:0] pulse_width_i = 4'd1;
  logic       frame_o, frame_start_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  frame_sync_gen #(.DIV_RATIO(DIV)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_mode_i(pulse_mode_i),
    .pulse_width_i(pulse_width_i), .frame_o(frame_o), .frame_start_o(frame_start_o)
  );

  always #2ns clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync_start();
    @(negedge clk_i);
    while (!frame_start_o) @(negedge clk_i);
  endtask

  // walk one frame from its strobe cycle; optional control change at cycle chg_at
  task automatic measure(input int exp, input int chg_at, input bit nm, input logic [3:0] nw,
                         output int highs, output int errs, output int starts);
    highs = 0; errs = 0; starts = 0;
    for (int i = 0; i < DIV; i++) begin
      if (frame_o) highs++;
      if (frame_o != (i < exp)) errs++;
      if (frame_start_o) starts++;
      if (i == chg_at) begin
        pulse_mode_i  = nm;
        pulse_width_i = nw;
      end
      @(negedge clk_i);
    end
  endtask

  initial begin
    int h, e, s;
    repeat (3) @(negedge clk_i);
    chk(!frame_o && !frame_start_o, "R7 reset quiet", {frame_o, frame_start_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(frame_start_o && frame_o, "R7 first frame", {frame_o, frame_start_o}, 3);

    for (int v = 0; v < NV; v++) begin
      pulse_mode_i  = VEC[v][9];
      pulse_width_i = VEC[v][8:5];
      sync_start();
      measure(int'(VEC[v][4:0]), -1, 1'b0, 4'd0, h, e, s);
      chk(e == 0 && h == int'(VEC[v][4:0]),
          VEC[v][9] ? (VEC[v][8:5] == 0 ? "R5 zero width" : "R4 pulse width") : "R3 half duty",
          h, int'(VEC[v][4:0]));
      chk(s == 1 && frame_start_o, "R1 R2 period and strobe", s, 1);
    end

    // width change inside a running pulse frame
    pulse_mode_i = 1'b1; pulse_width_i = 4'd3;
    sync_start();
    measure(3, 1, 1'b1, 4'd12, h, e, s);
    chk(e == 0 && h == 3, "R6 width held in frame", h, 3);
    measure(12, -1, 1'b0, 4'd0, h, e, s);
    chk(e == 0 && h == 12, "R6 width applied next frame", h, 12);

    // mode change inside a running half-duty frame
    pulse_mode_i = 1'b0; pulse_width_i = 4'd4;
    sync_start();
    measure(HALF, 2, 1'b1, 4'd4, h, e, s);
    chk(e == 0 && h == HALF, "R6 mode held in frame", h, HALF);
    measure(4, -1, 1'b0, 4'd0, h, e, s);
    chk(e == 0 && h == 4, "R6 mode applied next frame", h, 4);

    // reset in the middle of a frame
    pulse_mode_i = 1'b0;
    sync_start();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1ns;
    chk(!frame_o && !frame_start_o, "R7 async reset clears", {frame_o, frame_start_o}, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(frame_start_o && frame_o, "R7 restart after reset", {frame_o, frame_start_o}, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule